// File: doc/BRIEF.md
# Four-Rail Supply Sequencer

This block brings up and tears down the supply rails of a transceiver in a fixed order. Two rails come from switching regulators that are turned on by a run pin and that report a power-good flag. The other two rails come from a linear regulator and a charge pump. They are held off by an active-low shutdown pin, and an external voltage comparison reports whether each is in range. The sequencer mixes both kinds in one chain. It enables one rail and waits for that rail's good or in-range flag before it enables the next.

A power-up request starts the chain. A power-down request, or any fault, tears the chain down from the most recently enabled rail back to the first. Between two rails the sequencer waits a settle delay. A fault is either a rail that misses its own timeout while ramping, or a rail whose flag drops while all rails are on. After a fault the block parks in a halted state and holds the index of the rail that failed. A power-down request clears the halt. The index stays readable until the next accepted power-up. All good and in-range inputs are asynchronous and pass through two-flop synchronizers.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Power-up enables the rails strictly one at a time in the order sequence position 0 (-4 V charge pump), 1 (+6 V low-power switcher), 2 (+9 V linear), 3 (+6 V high-power switcher). A rail is enabled in the cycle after the sequencer sees the synchronized good flag of the rail before it, and the state reads 2 (on) once rail 3's flag is seen.
- R2: Every good and in-range input passes through two flops. A flag that rises ahead of clock edge E first affects the enables at edge E+2.
- R3: While ramping, a rail whose synchronized flag is still low in the last cycle of its timeout (RAIL_TIMEOUT cycles counted from the edge that enabled it) raises a fault with that rail's position as the fault index.
- R4: In the on state (2), a low synchronized flag on any rail raises a fault. The fault index is the lowest position whose flag is low.
- R5: On a fault, every enabled rail is switched off in reverse order, one per SETTLE_CYC cycles. The state then reads 4 (halted) with the fault output high and all enables low.
- R6: A power-down request in the ramping (1) or on (2) state switches off the enabled rails in reverse order with the same settle spacing, then returns to state 0 (off) with no fault.
- R7: A power-up request is ignored in every state except off (0): the state and the enables are unchanged by it.
- R8: A power-down request in the halted state moves to off and clears the fault output. The fault index keeps its value until the next accepted power-up request, which resets it to 0.
- R9: After reset, all enables are low, the state is 0, the fault output is low and the fault index is 0.
- R10: The switching rails (positions 1 and 3) drive run outputs 0 and 1, and their power-good flags are read from the power-good inputs 0 and 1. The other rails (positions 0 and 2) drive shutdown outputs 0 and 1, with high meaning running, and their flags are read from the in-range inputs 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req_i | input | 1 | Power-up request, sampled each cycle |
| down_req_i | input | 1 | Power-down request, sampled each cycle; takes priority over up |
| sw_pgood_i | input | N_SW (2) | Power-good flags of the switching rails, asynchronous |
| lin_inrange_i | input | N_LIN (2) | In-range flags of the linear and charge-pump rails, asynchronous |
| sw_run_o | output | N_SW (2) | Run enables of the switching rails, active high |
| lin_shdn_n_o | output | N_LIN (2) | Shutdown controls of the linear and charge-pump rails, active low |
| state_o | output | 3 | 0 off, 1 ramping, 2 on, 3 shutting down, 4 halted on fault |
| fault_o | output | 1 | Fault latched |
| fault_rail_o | output | IDX_W (2) | Sequence position of the rail that faulted |

## Verification
The bench builds the block with 8-bit timers, per-rail timeouts of 8, 12, 10 and 6 cycles, and a settle delay of 3 cycles. With these values every ramp timeout and every reverse shutdown completes within a few dozen cycles. The good flag of a rail can therefore be placed on the last cycle the timeout allows, and one cycle later, within a short run. The small timeout of the final rail, with the two-flop latency, leaves only a narrow window for its flag. This exercises the exact counting of the timer.

// File: rtl/pseq_pkg.sv
// Package: shared state encoding and helpers that map sequence positions
// to the per-kind port indices (switching rails vs monitored rails).
package pseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_RAMP = 3'd1,
        ST_ON   = 3'd2,
        ST_DOWN = 3'd3,
        ST_HALT = 3'd4
    } seq_state_e;

    // Number of positions below n whose kind bit equals val.
    function automatic int kind_count(input logic [31:0] kind, input int n, input logic val);
        int c;
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (kind[i] == val) c++;
        end
        return c;
    endfunction

    // Port index of position pos within its own kind group.
    function automatic int kind_pos(input logic [31:0] kind, input int pos);
        return kind_count(kind, pos, kind[pos]);
    endfunction

endpackage

// File: rtl/sync_2ff.sv
// sync_2ff: two-flop synchronizer for a vector of independent asynchronous
// level flags. Assumes each bit is a slow level; no bus coherency is implied.
module sync_2ff #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Two register stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/seq_fsm.sv
// seq_fsm: ordered enable/disable controller for N rails. Enables position
// 0 first and waits for each synchronized good flag, with a per-position
// timeout. Tears down in reverse with a settle gap on request or fault.
// Assumes good_i is already synchronized and every timeout is at least 1.
module seq_fsm
    import pseq_pkg::*;
#(
    parameter int                          N_RAILS      = 4,
    parameter int                          CNT_W        = 16,
    parameter logic [N_RAILS*CNT_W-1:0]    RAIL_TIMEOUT = {N_RAILS{CNT_W'(1000)}},
    parameter int unsigned                 SETTLE_CYC   = 64,
    localparam int                         IDX_W        = (N_RAILS > 1) ? $clog2(N_RAILS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up_req_i,
    input  logic               down_req_i,
    input  logic [N_RAILS-1:0] good_i,
    output logic [N_RAILS-1:0] en_o,
    output logic [2:0]         state_o,
    output logic               fault_o,
    output logic [IDX_W-1:0]   fault_rail_o
);
    localparam logic [IDX_W-1:0] LAST_POS   = IDX_W'(N_RAILS - 1);
    localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE_CYC - 1);

    seq_state_e          state_q, state_d;
    logic [IDX_W-1:0]    step_q, step_d;
    logic [CNT_W-1:0]    timer_q, timer_d;
    logic [N_RAILS-1:0]  en_q, en_d;
    logic                fault_q, fault_d;
    logic [IDX_W-1:0]    frail_q, frail_d;
    logic [CNT_W-1:0]    to_cur;
    logic [IDX_W-1:0]    low_idx;
    logic                any_low;

    assign to_cur = RAIL_TIMEOUT[step_q*CNT_W +: CNT_W];

    // Lowest position whose good flag is low.
    always_comb begin
        low_idx = '0;
        any_low = 1'b0;
        for (int i = N_RAILS - 1; i >= 0; i--) begin
            if (!good_i[i]) begin
                low_idx = IDX_W'(i);
                any_low = 1'b1;
            end
        end
    end

    // Next-state logic for sequencing, timing and fault latching.
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        timer_d = timer_q + 1'b1;
        en_d    = en_q;
        fault_d = fault_q;
        frail_d = frail_q;
        case (state_q)
            ST_OFF: begin
                timer_d = '0;
                if (up_req_i && !down_req_i) begin
                    state_d = ST_RAMP;
                    step_d  = '0;
                    en_d    = N_RAILS'(1);
                    frail_d = '0;
                end
            end
            ST_RAMP: begin
                if (down_req_i) begin
                    state_d      = ST_DOWN;
                    timer_d      = '0;
                    en_d[step_q] = 1'b0;
                end else if (good_i[step_q]) begin
                    timer_d = '0;
                    if (step_q == LAST_POS) begin
                        state_d = ST_ON;
                    end else begin
                        step_d               = step_q + 1'b1;
                        en_d[step_q + 1'b1]  = 1'b1;
                    end
                end else if (timer_q == to_cur - 1'b1) begin
                    fault_d      = 1'b1;
                    frail_d      = step_q;
                    state_d      = ST_DOWN;
                    timer_d      = '0;
                    en_d[step_q] = 1'b0;
                end
            end
            ST_ON: begin
                timer_d = '0;
                if (down_req_i || any_low) begin
                    if (!down_req_i) begin
                        fault_d = 1'b1;
                        frail_d = low_idx;
                    end
                    state_d        = ST_DOWN;
                    step_d         = LAST_POS;
                    en_d[LAST_POS] = 1'b0;
                end
            end
            ST_DOWN: begin
                if (timer_q == SETTLE_END) begin
                    timer_d = '0;
                    if (step_q == '0) begin
                        state_d = fault_q ? ST_HALT : ST_OFF;
                    end else begin
                        step_d                = step_q - 1'b1;
                        en_d[step_q - 1'b1]   = 1'b0;
                    end
                end
            end
            ST_HALT: begin
                timer_d = '0;
                if (down_req_i) begin
                    state_d = ST_OFF;
                    fault_d = 1'b0;
                end
            end
            default: begin
                state_d = ST_OFF;
                en_d    = '0;
            end
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            step_q  <= '0;
            timer_q <= '0;
            en_q    <= '0;
            fault_q <= 1'b0;
            frail_q <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            timer_q <= timer_d;
            en_q    <= en_d;
            fault_q <= fault_d;
            frail_q <= frail_d;
        end
    end

    assign en_o         = en_q;
    assign state_o      = state_q;
    assign fault_o      = fault_q;
    assign fault_rail_o = frail_q;

    // R1
    en_rise_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(en_q & ~$past(en_q)) <= 1);

    // R5
    en_fall_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~en_q & $past(en_q)) <= 1);

    // R6
    no_rise_in_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN) |=> ((en_q & ~$past(en_q)) == '0));

    // R3
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP) |-> (timer_q < to_cur));

    // R7
    halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !down_req_i) |=> (state_q == ST_HALT));

    // R8
    fault_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !(state_q == ST_HALT && down_req_i)) |=> (fault_q && $stable(frail_q)));
endmodule

// File: rtl/pwr_seq_ctrl.sv
// pwr_seq_ctrl: top of the rail sequencer. Routes each sequence position to
// a run/power-good pair (switching rail) or a shutdown/in-range pair
// (monitored rail) according to RAIL_KIND, synchronizes the flags and
// hands them to the sequencing FSM. Assumes RAIL_KIND holds both kinds.
module pwr_seq_ctrl
    import pseq_pkg::*;
#(
    parameter int                       N_RAILS      = 4,
    parameter logic [N_RAILS-1:0]       RAIL_KIND    = 4'b1010,
    parameter int                       CNT_W        = 16,
    parameter logic [N_RAILS*CNT_W-1:0] RAIL_TIMEOUT = {N_RAILS{CNT_W'(1000)}},
    parameter int unsigned              SETTLE_CYC   = 64,
    localparam int                      N_SW         = kind_count(32'(RAIL_KIND), N_RAILS, 1'b1),
    localparam int                      N_LIN        = N_RAILS - N_SW,
    localparam int                      IDX_W        = (N_RAILS > 1) ? $clog2(N_RAILS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_req_i,
    input  logic             down_req_i,
    input  logic [N_SW-1:0]  sw_pgood_i,
    input  logic [N_LIN-1:0] lin_inrange_i,
    output logic [N_SW-1:0]  sw_run_o,
    output logic [N_LIN-1:0] lin_shdn_n_o,
    output logic [2:0]       state_o,
    output logic             fault_o,
    output logic [IDX_W-1:0] fault_rail_o
);
    logic [N_RAILS-1:0] good_raw;
    logic [N_RAILS-1:0] good_sync;
    logic [N_RAILS-1:0] rail_en;

    // Per-position routing between sequence order and kind-specific ports.
    for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
        localparam int SUB = kind_pos(32'(RAIL_KIND), g);
        if (RAIL_KIND[g]) begin : g_sw
            assign sw_run_o[SUB] = rail_en[g];
            assign good_raw[g]   = sw_pgood_i[SUB];
        end else begin : g_lin
            assign lin_shdn_n_o[SUB] = rail_en[g];
            assign good_raw[g]       = lin_inrange_i[SUB];
        end
    end

    sync_2ff #(.W(N_RAILS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (good_raw),
        .q_o   (good_sync)
    );

    seq_fsm #(
        .N_RAILS      (N_RAILS),
        .CNT_W        (CNT_W),
        .RAIL_TIMEOUT (RAIL_TIMEOUT),
        .SETTLE_CYC   (SETTLE_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .up_req_i     (up_req_i),
        .down_req_i   (down_req_i),
        .good_i       (good_sync),
        .en_o         (rail_en),
        .state_o      (state_o),
        .fault_o      (fault_o),
        .fault_rail_o (fault_rail_o)
    );
endmodule

// File: tb/sim_pwr_seq_ctrl.sv
// Bench: behavioural reference model compared every cycle, plus a rail
// plant that raises each flag a programmable delay after its enable.
module sim_pwr_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE = 3;
    localparam int TO_TAB [4] = '{8, 12, 10, 6};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_req = 1'b0;
    logic down_req = 1'b0;
    logic [1:0] sw_pgood, lin_inrange, sw_run, lin_shdn_n;
    logic [2:0] state;
    logic fault;
    logic [1:0] fault_rail;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_seq_ctrl #(
        .N_RAILS(4), .RAIL_KIND(4'b1010), .CNT_W(8),
        .RAIL_TIMEOUT({8'd6, 8'd10, 8'd12, 8'd8}), .SETTLE_CYC(SETTLE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .up_req_i(up_req), .down_req_i(down_req),
        .sw_pgood_i(sw_pgood), .lin_inrange_i(lin_inrange),
        .sw_run_o(sw_run), .lin_shdn_n_o(lin_shdn_n),
        .state_o(state), .fault_o(fault), .fault_rail_o(fault_rail)
    );

    int compared = 0;
    int mismatched = 0;

    // Rail plant (R10 mapping: positions 0,2 on shutdown/in-range; 1,3 on run/pgood)
    logic [3:0] en_dut;
    assign en_dut = {sw_run[1], lin_shdn_n[1], sw_run[0], lin_shdn_n[0]};
    int  delay [4] = '{1, 2, 3, 0};
    bit  block [4] = '{0, 0, 0, 0};
    bit  drop  [4] = '{0, 0, 0, 0};
    int  on_cnt [4] = '{0, 0, 0, 0};
    logic [3:0] good_vec = '0;
    assign lin_inrange = {good_vec[2], good_vec[0]};
    assign sw_pgood    = {good_vec[3], good_vec[1]};

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (!en_dut[i]) begin
                on_cnt[i] = 0;
                good_vec[i] = 1'b0;
            end else begin
                good_vec[i] = (on_cnt[i] >= delay[i]) && !block[i] && !drop[i];
                on_cnt[i]++;
            end
        end
    end

    // Reference model: synchronizer as a queue, sequencing with integers
    logic [3:0] sq[$];
    int m_state, m_step, m_timer, m_frail;
    bit m_fault;
    logic [3:0] m_en;

    task automatic m_go_down(int from);
        m_state = 3; m_step = from; m_timer = 0; m_en[from] = 1'b0;
    endtask

    always @(posedge clk) begin
        logic [3:0] sg;
        if (!rst_n) begin
            sq = '{4'b0, 4'b0};
            m_state = 0; m_step = 0; m_timer = 0; m_frail = 0; m_fault = 0; m_en = '0;
        end else begin
            sg = sq[0];
            case (m_state)
                0: if (up_req && !down_req) begin
                       m_state = 1; m_step = 0; m_timer = 0; m_en = 4'b0001; m_frail = 0;
                   end
                1: if (down_req) m_go_down(m_step);
                   else if (sg[m_step]) begin
                       m_timer = 0;
                       if (m_step == 3) m_state = 2;
                       else begin m_step++; m_en[m_step] = 1'b1; end
                   end else if (m_timer == TO_TAB[m_step] - 1) begin
                       m_fault = 1; m_frail = m_step; m_go_down(m_step);
                   end else m_timer++;
                2: if (down_req) m_go_down(3);
                   else if (sg != 4'hF) begin
                       m_fault = 1;
                       for (int i = 3; i >= 0; i--) if (!sg[i]) m_frail = i;
                       m_go_down(3);
                   end
                3: if (m_timer == SETTLE - 1) begin
                       m_timer = 0;
                       if (m_step == 0) m_state = m_fault ? 4 : 0;
                       else begin m_step--; m_en[m_step] = 1'b0; end
                   end else m_timer++;
                4: if (down_req) begin m_state = 0; m_fault = 0; end
                default: m_state = 0;
            endcase
            void'(sq.pop_front());
            sq.push_back(good_vec);
        end
    end

    function automatic string tag_of(int s);
        case (s)
            0: return "R9/R6";
            1: return "R1/R2/R3";
            2: return "R4/R7";
            3: return "R5/R6";
            default: return "R8";
        endcase
    endfunction

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            compared++;
            if (en_dut !== m_en || state !== 3'(m_state) || fault !== m_fault ||
                fault_rail !== 2'(m_frail)) begin
                mismatched++;
                $display("FAIL %s: en/state/fault/idx act=%b/%0d/%b/%0d exp=%b/%0d/%b/%0d",
                         tag_of(m_state), en_dut, state, fault, fault_rail,
                         m_en, m_state, m_fault, m_frail);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_up();
        @(negedge clk) up_req = 1'b1;
        @(negedge clk) up_req = 1'b0;
    endtask

    task automatic pulse_down();
        @(negedge clk) down_req = 1'b1;
        @(negedge clk) down_req = 1'b0;
    endtask

    task automatic wait_state(input int s);
        for (int i = 0; i < 200; i++) begin
            if (state == 3'(s)) return;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: act=running exp=finished");
        finish_run();
    end

    initial begin
        int t0;
        repeat (4) @(negedge clk);
        // R9 reset state
        chk("R9 state", state, 0);
        chk("R9 enables", en_dut, 0);
        chk("R9 fault", fault, 0);
        chk("R9 index", fault_rail, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1/R10/R2 normal power-up
        pulse_up();
        chk("R10 first rail on shutdown pin 0", lin_shdn_n, 1);
        chk("R10 run pins still low", sw_run, 0);
        t0 = 0;
        while (!en_dut[1] && t0 < 50) begin @(negedge clk); t0++; end
        chk("R2 gap rail0->rail1 (delay 1 + 3)", t0, 4);
        wait_state(2);
        chk("R1 reached on", state, 2);
        chk("R1 all enabled", en_dut, 15);
        // R7 up request ignored when on
        pulse_up();
        repeat (3) @(negedge clk);
        chk("R7 up ignored in on", state, 2);
        // R6 orderly power-down
        pulse_down();
        wait_state(0);
        chk("R6 off after down", state, 0);
        chk("R6 enables off", en_dut, 0);
        chk("R6 no fault", fault, 0);

        // R7 up during ramp, then R4 drop in on state
        pulse_up();
        pulse_up();
        wait_state(2);
        chk("R7 ramp unaffected, on", state, 2);
        repeat (2) @(negedge clk);
        drop[2] = 1;
        wait_state(4);
        chk("R4 fault index", fault_rail, 2);
        chk("R5 halted fault", fault, 1);
        chk("R5 all off", en_dut, 0);
        drop[2] = 0;
        pulse_up();
        repeat (2) @(negedge clk);
        chk("R7 up ignored in halt", state, 4);
        pulse_down();
        chk("R8 off after down", state, 0);
        chk("R8 fault cleared", fault, 0);
        chk("R8 index kept", fault_rail, 2);
        pulse_up();
        chk("R8 index reset on accepted up", fault_rail, 0);
        wait_state(2);
        pulse_down();
        wait_state(0);

        // R3 timeout on rail 1
        block[1] = 1;
        pulse_up();
        wait_state(4);
        chk("R3 timeout index", fault_rail, 1);
        chk("R3 fault", fault, 1);
        pulse_down();
        block[1] = 0;

        // R3 boundary on rail 2 (timeout 10): delay 7 passes, 8 fails
        delay[2] = 7;
        pulse_up();
        wait_state(2);
        chk("R3 last allowed cycle reaches on", state, 2);
        pulse_down();
        wait_state(0);
        delay[2] = 8;
        pulse_up();
        wait_state(4);
        chk("R3 one late faults", fault_rail, 2);
        pulse_down();
        delay[2] = 3;

        // R6 power-down during ramp
        delay[3] = 3;
        pulse_up();
        repeat (6) @(negedge clk);
        pulse_down();
        wait_state(0);
        chk("R6 off after down in ramp", state, 0);
        chk("R6 no fault after ramp abort", fault, 0);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule